// File: doc/BRIEF.md
# Banked Enhanced Register Decoder for a 16550-Style Serial Port

This block is the byte-wide register front end of a 16550-style serial controller. The normal eight-offset map is kept as it is: receive and transmit data, interrupt enable, FIFO control and interrupt identification, line control, modem control, line and modem status, and scratch. The divisor latch appears at offsets 0 and 1 while bit 7 of the line control register is set.

A hidden set of enhanced registers sits behind this map. The key is a line control value, 0xBF by default. While the line control register holds the key, offset 2 reaches a feature register. Offsets 4 to 7 then reach one of several banks, which bits 7:6 of the feature register select. Bank 0 holds the flow-control characters. Bank 1 holds the FIFO water levels. Bank 2 holds an enumeration byte, a read-only identity byte, an extended control byte and a control/status byte. Writing any other line control value closes the enhanced view on the next access, and every enhanced value is kept.

With bit 4 of the feature register set, a read of offset 7 in the normal map returns the good-data length, which comes from the receive path. Every configured value is exported as a port for the serial engine, and the status inputs of that engine are read through the map.

Top module: `uart_bank_regs`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every stored register is 0x00, `bus_rdata` is 0x00, `tx_push_o` is 0 and `key_active_o` is 0.
- R2: The normal map is decoded as follows while the line control register does not hold the key.
  - Offset 1 reads and writes interrupt enable while line control bit 7 is 0.
  - Offset 2 writes FIFO control and reads `int_ident_i`.
  - Offset 4 reads and writes modem control.
  - Offsets 5 and 6 read `line_stat_i` and `modem_stat_i`, and writes to them change nothing.
  - Offset 0, with line control bit 7 at 0, reads `rx_byte_i`. A write there sets `tx_byte_o` and raises `tx_push_o` for exactly the one cycle after the write.
- R3: While line control bit 7 is 1, key value included, offsets 0 and 1 read and write the low and high bytes of the divisor, `divisor_o` = {high, low`}`. A write to offset 0 then raises no `tx_push_o`.
- R4: While the line control register holds the key, `key_active_o` is 1. In that state offset 2 reads and writes the feature register (`feature_o`), and FIFO control is not changed.
- R5: With the key held and feature bits 7:6 = 0, offsets 4, 5, 6 and 7 read and write XON1, XON2, XOFF1 and XOFF2.
- R6: With the key held and feature bits 7:6 = 1, offsets 4, 5, 6 and 7 read and write the receive low level, the receive high level, the receive trigger level and the transmit threshold.
- R7: With the key held and feature bits 7:6 = 2, offsets 4, 6 and 7 read and write enumeration, extended control and control/status. Offset 5 reads the `HW_ID` parameter, and writes to it are ignored.
- R8: With the key held and feature bits 7:6 = 3, offsets 4 to 7 read 0x00, and writes to them change no register.
- R9: In the normal map, a read of offset 7 returns {`bad_flag_i`, `good_count_i`} while feature bit 4 is 1, and the scratch byte while it is 0. A write to offset 7 in the normal map always goes to scratch.
- R10: Offset 3 reads and writes line control in both views. Once a non-key value is written, the next access uses the normal map. Feature and bank values are kept, and normal-map writes to offsets 4 to 7 change no bank register.
- R11: `bus_rdata` changes only on the clock edge that ends a cycle with `bus_rd` high, and it holds between reads. Decoding uses the register values from before that edge, so a read and a write in the same cycle return the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| rx_byte_i | input | 8 | Received byte from the serial engine |
| int_ident_i | input | 8 | Interrupt identification value |
| line_stat_i | input | 8 | Line status value |
| modem_stat_i | input | 8 | Modem status value |
| good_count_i | input | 7 | Good-data byte count |
| bad_flag_i | input | 1 | Bad data present in the receive FIFO |
| tx_push_o | output | 1 | One-cycle transmit byte strobe |
| tx_byte_o | output | 8 | Last byte written for transmission |
| divisor_o | output | 16 | Baud divisor {high, low} |
| int_enable_o | output | 8 | Interrupt enable |
| fifo_ctl_o | output | 8 | FIFO control |
| line_ctl_o | output | 8 | Line control |
| modem_ctl_o | output | 8 | Modem control |
| feature_o | output | 8 | Feature register (bank select, enable bit) |
| xon1_o | output | 8 | First XON character |
| xon2_o | output | 8 | Second XON character |
| xoff1_o | output | 8 | First XOFF character |
| xoff2_o | output | 8 | Second XOFF character |
| rx_low_o | output | 8 | Receive low-water level |
| rx_high_o | output | 8 | Receive high-water level |
| rx_trig_o | output | 8 | Receive trigger level |
| tx_thresh_o | output | 8 | Transmit threshold |
| enum_o | output | 8 | Enumeration byte |
| ext_ctl_o | output | 8 | Extended control |
| ctl_stat_o | output | 8 | Control/status byte |
| key_active_o | output | 1 | Enhanced view open |

## Verification
Every exported register takes its new value on the rising edge that ends the write cycle. `bus_rdata` takes the read value on the rising edge that ends the read cycle. `tx_push_o` is high for the one cycle after that edge, so every result is due one edge after its stimulus. The bench drives each access on a falling edge and steps its behavioural model just after the following rising edge, using the inputs held across that edge. It then compares all outputs on the next falling edge, so each comparison falls exactly one edge after the stimulus that caused it. A same-cycle read and write of line control checks that decoding sees the pre-edge register state.

// File: rtl/ubk_pkg.sv
package ubk_pkg;

    localparam int DW         = 8;
    localparam int AW         = 3;
    localparam int SLOTS      = 4;
    localparam int BANKS      = 3;
    localparam int BANK_SEL_W = 2;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BANK_LSB   = 6;
    localparam int ENH_BIT    = 4;
    localparam int DLAB_BIT   = 7;
    localparam int HWID_BANK  = 2;
    localparam int HWID_SLOT  = 1;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [3:0] {
        S_NONE,
        S_RXTX,
        S_DLL,
        S_DLM,
        S_IER,
        S_FIFO,
        S_LCR,
        S_MCR,
        S_LSR,
        S_MSR,
        S_SCR,
        S_GOOD,
        S_EFR,
        S_BANK
    } sel_e;

    typedef struct packed {
        byte_t dll;
        byte_t dlm;
        byte_t ier;
        byte_t fcr;
        byte_t lcr;
        byte_t mcr;
        byte_t scr;
        byte_t efr;
        byte_t txb;
        logic  txp;
        byte_t rdata;
        logic [BANKS-1:0][SLOTS-1:0][DW-1:0] bank;
    } state_t;

endpackage

// File: rtl/ubk_decode.sv
module ubk_decode
    import ubk_pkg::*;
#(
    parameter byte_t LCR_KEY = 8'hBF
) (
    input  logic [AW-1:0]         addr,
    input  byte_t                 lcr,
    input  logic [BANK_SEL_W-1:0] bank_sel,
    input  logic                  enh_on,
    output sel_e                  rd_sel,
    output sel_e                  wr_sel,
    output logic [BANK_SEL_W-1:0] bank_idx,
    output logic [SLOT_W-1:0]     slot_idx
);

    logic key_open;
    logic dlab;
    logic bank_ok;

    always_comb begin
        key_open = (lcr == LCR_KEY);
        dlab     = lcr[DLAB_BIT];
        bank_ok  = (int'(bank_sel) < BANKS);
        bank_idx = bank_sel;
        slot_idx = addr[SLOT_W-1:0];
        rd_sel   = S_NONE;
        wr_sel   = S_NONE;
        case (addr)
            3'd0: begin
                rd_sel = dlab ? S_DLL : S_RXTX;
                wr_sel = rd_sel;
            end
            3'd1: begin
                rd_sel = dlab ? S_DLM : S_IER;
                wr_sel = rd_sel;
            end
            3'd2: begin
                rd_sel = key_open ? S_EFR : S_FIFO;
                wr_sel = rd_sel;
            end
            3'd3: begin
                rd_sel = S_LCR;
                wr_sel = S_LCR;
            end
            default: begin
                if (key_open) begin
                    // upper offsets go to the selected bank
                    rd_sel = bank_ok ? S_BANK : S_NONE;
                    wr_sel = rd_sel;
                end else begin
                    case (addr[1:0])
                        2'd0: begin
                            rd_sel = S_MCR;
                            wr_sel = S_MCR;
                        end
                        2'd1:    rd_sel = S_LSR;
                        2'd2:    rd_sel = S_MSR;
                        default: begin
                            rd_sel = enh_on ? S_GOOD : S_SCR;
                            wr_sel = S_SCR;
                        end
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/ubk_readmux.sv
module ubk_readmux
    import ubk_pkg::*;
#(
    parameter byte_t HW_ID = 8'hA5
) (
    input  sel_e                  rd_sel,
    input  logic [BANK_SEL_W-1:0] bank_idx,
    input  logic [SLOT_W-1:0]     slot_idx,
    input  byte_t                 dll,
    input  byte_t                 dlm,
    input  byte_t                 ier,
    input  byte_t                 lcr,
    input  byte_t                 mcr,
    input  byte_t                 scr,
    input  byte_t                 efr,
    input  logic [BANKS-1:0][SLOTS-1:0][DW-1:0] bank,
    input  byte_t                 rx_byte,
    input  byte_t                 int_ident,
    input  byte_t                 line_stat,
    input  byte_t                 modem_stat,
    input  logic [DW-2:0]         good_count,
    input  logic                  bad_flag,
    output byte_t                 rd_val
);

    always_comb begin
        rd_val = '0;
        case (rd_sel)
            S_RXTX: rd_val = rx_byte;
            S_DLL:  rd_val = dll;
            S_DLM:  rd_val = dlm;
            S_IER:  rd_val = ier;
            S_FIFO: rd_val = int_ident;
            S_LCR:  rd_val = lcr;
            S_MCR:  rd_val = mcr;
            S_LSR:  rd_val = line_stat;
            S_MSR:  rd_val = modem_stat;
            S_SCR:  rd_val = scr;
            S_GOOD: rd_val = {bad_flag, good_count};
            S_EFR:  rd_val = efr;
            S_BANK: begin
                for (int b = 0; b < BANKS; b++) begin
                    for (int s = 0; s < SLOTS; s++) begin
                        if (b == int'(bank_idx) && s == int'(slot_idx)) begin
                            rd_val = (b == HWID_BANK && s == HWID_SLOT) ? HW_ID : bank[b][s];
                        end
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

endmodule

// File: rtl/ubk_regfile.sv
module ubk_regfile
    import ubk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  byte_t                 wdata,
    input  sel_e                  wr_sel,
    input  logic [BANK_SEL_W-1:0] bank_idx,
    input  logic [SLOT_W-1:0]     slot_idx,
    input  byte_t                 rd_val,
    output state_t                st_q
);

    state_t st_d;

    always_comb begin
        st_d     = st_q;
        st_d.txp = 1'b0;
        if (bus_rd) begin
            st_d.rdata = rd_val;
        end
        if (bus_wr) begin
            case (wr_sel)
                S_RXTX: begin
                    st_d.txb = wdata;
                    st_d.txp = 1'b1;
                end
                S_DLL:  st_d.dll = wdata;
                S_DLM:  st_d.dlm = wdata;
                S_IER:  st_d.ier = wdata;
                S_FIFO: st_d.fcr = wdata;
                S_LCR:  st_d.lcr = wdata;
                S_MCR:  st_d.mcr = wdata;
                S_SCR:  st_d.scr = wdata;
                S_EFR:  st_d.efr = wdata;
                S_BANK: begin
                    for (int b = 0; b < BANKS; b++) begin
                        for (int s = 0; s < SLOTS; s++) begin
                            // identity slot is read-only
                            if (b == int'(bank_idx) && s == int'(slot_idx) &&
                                !(b == HWID_BANK && s == HWID_SLOT)) begin
                                st_d.bank[b][s] = wdata;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import ubk_pkg::*;
#(
    parameter logic [7:0] LCR_KEY = 8'hBF,
    parameter logic [7:0] HW_ID   = 8'hA5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  rx_byte_i,
    input  logic [7:0]  int_ident_i,
    input  logic [7:0]  line_stat_i,
    input  logic [7:0]  modem_stat_i,
    input  logic [6:0]  good_count_i,
    input  logic        bad_flag_i,
    output logic        tx_push_o,
    output logic [7:0]  tx_byte_o,
    output logic [15:0] divisor_o,
    output logic [7:0]  int_enable_o,
    output logic [7:0]  fifo_ctl_o,
    output logic [7:0]  line_ctl_o,
    output logic [7:0]  modem_ctl_o,
    output logic [7:0]  feature_o,
    output logic [7:0]  xon1_o,
    output logic [7:0]  xon2_o,
    output logic [7:0]  xoff1_o,
    output logic [7:0]  xoff2_o,
    output logic [7:0]  rx_low_o,
    output logic [7:0]  rx_high_o,
    output logic [7:0]  rx_trig_o,
    output logic [7:0]  tx_thresh_o,
    output logic [7:0]  enum_o,
    output logic [7:0]  ext_ctl_o,
    output logic [7:0]  ctl_stat_o,
    output logic        key_active_o
);

    state_t                st;
    sel_e                  rd_sel;
    sel_e                  wr_sel;
    logic [BANK_SEL_W-1:0] bank_idx;
    logic [SLOT_W-1:0]     slot_idx;
    byte_t                 rd_val;

    ubk_decode #(.LCR_KEY(LCR_KEY)) u_decode (
        .addr     (bus_addr),
        .lcr      (st.lcr),
        .bank_sel (st.efr[BANK_LSB +: BANK_SEL_W]),
        .enh_on   (st.efr[ENH_BIT]),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel),
        .bank_idx (bank_idx),
        .slot_idx (slot_idx)
    );

    ubk_readmux #(.HW_ID(HW_ID)) u_readmux (
        .rd_sel     (rd_sel),
        .bank_idx   (bank_idx),
        .slot_idx   (slot_idx),
        .dll        (st.dll),
        .dlm        (st.dlm),
        .ier        (st.ier),
        .lcr        (st.lcr),
        .mcr        (st.mcr),
        .scr        (st.scr),
        .efr        (st.efr),
        .bank       (st.bank),
        .rx_byte    (rx_byte_i),
        .int_ident  (int_ident_i),
        .line_stat  (line_stat_i),
        .modem_stat (modem_stat_i),
        .good_count (good_count_i),
        .bad_flag   (bad_flag_i),
        .rd_val     (rd_val)
    );

    ubk_regfile u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wdata    (bus_wdata),
        .wr_sel   (wr_sel),
        .bank_idx (bank_idx),
        .slot_idx (slot_idx),
        .rd_val   (rd_val),
        .st_q     (st)
    );

    assign bus_rdata    = st.rdata;
    assign tx_push_o    = st.txp;
    assign tx_byte_o    = st.txb;
    assign divisor_o    = {st.dlm, st.dll};
    assign int_enable_o = st.ier;
    assign fifo_ctl_o   = st.fcr;
    assign line_ctl_o   = st.lcr;
    assign modem_ctl_o  = st.mcr;
    assign feature_o    = st.efr;
    assign xon1_o       = st.bank[0][0];
    assign xon2_o       = st.bank[0][1];
    assign xoff1_o      = st.bank[0][2];
    assign xoff2_o      = st.bank[0][3];
    assign rx_low_o     = st.bank[1][0];
    assign rx_high_o    = st.bank[1][1];
    assign rx_trig_o    = st.bank[1][2];
    assign tx_thresh_o  = st.bank[1][3];
    assign enum_o       = st.bank[2][0];
    assign ext_ctl_o    = st.bank[2][2];
    assign ctl_stat_o   = st.bank[2][3];
    assign key_active_o = (st.lcr == LCR_KEY);

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
    parameter logic [7:0] LCR_KEY = 8'hBF,
    parameter logic [7:0] HW_ID   = 8'hA5
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [6:0]  good_count_i,
    input logic        bad_flag_i,
    input logic        tx_push_o,
    input logic [7:0]  tx_byte_o,
    input logic [7:0]  line_ctl_o,
    input logic [7:0]  feature_o,
    input logic [87:0] bank_flat,
    input logic        key_active_o
);

    // R1: first cycle out of reset shows cleared state
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bus_rdata == 8'h00 && line_ctl_o == 8'h00 &&
                          feature_o == 8'h00 && bank_flat == '0 && !tx_push_o && !key_active_o));

    // R2: a data write in the normal map gives one strobe with the byte
    a_r2_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !line_ctl_o[7]) |=>
            (tx_push_o && tx_byte_o == $past(bus_wdata)));

    // R3: no strobe without such a write
    a_r3_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd0 && !line_ctl_o[7]) |=> !tx_push_o);

    // R7: identity slot reads the constant
    a_r7_hwid_read: assert property (@(posedge clk) disable iff (!rst_n)
        (key_active_o && bus_rd && bus_addr == 3'd5 && feature_o[7:6] == 2'd2) |=>
            (bus_rdata == HW_ID));

    // R8: writes to the empty bank touch nothing
    a_r8_bank3_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (key_active_o && bus_wr && bus_addr[2] && feature_o[7:6] == 2'd3) |=>
            $stable(bank_flat));

    // R9: good-data length readout
    a_r9_good_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_active_o && feature_o[4] && bus_rd && bus_addr == 3'd7) |=>
            (bus_rdata == $past({bad_flag_i, good_count_i})));

    // R10: enhanced values are frozen while the key is not held
    a_r10_banks_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !key_active_o |=> ($stable(bank_flat) && $stable(feature_o)));

    // R11: read data holds between reads
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind uart_bank_regs uart_bank_regs_chk #(.LCR_KEY(LCR_KEY), .HW_ID(HW_ID)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .good_count_i (good_count_i),
    .bad_flag_i   (bad_flag_i),
    .tx_push_o    (tx_push_o),
    .tx_byte_o    (tx_byte_o),
    .line_ctl_o   (line_ctl_o),
    .feature_o    (feature_o),
    .bank_flat    ({xon1_o, xon2_o, xoff1_o, xoff2_o, rx_low_o, rx_high_o,
                    rx_trig_o, tx_thresh_o, enum_o, ext_ctl_o, ctl_stat_o}),
    .key_active_o (key_active_o)
);

// File: tb/uart_bank_regs_bench.sv
module uart_bank_regs_bench;

    localparam logic [7:0] KEY  = 8'hBF;
    localparam logic [7:0] HWID = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  rx_byte = 8'h61;
    logic [7:0]  int_ident = 8'hC1;
    logic [7:0]  line_stat = 8'h60;
    logic [7:0]  modem_stat = 8'hB0;
    logic [6:0]  good_count = 7'd37;
    logic        bad_flag = 1'b1;
    logic        tx_push_o;
    logic [7:0]  tx_byte_o;
    logic [15:0] divisor_o;
    logic [7:0]  int_enable_o, fifo_ctl_o, line_ctl_o, modem_ctl_o, feature_o;
    logic [7:0]  xon1_o, xon2_o, xoff1_o, xoff2_o;
    logic [7:0]  rx_low_o, rx_high_o, rx_trig_o, tx_thresh_o;
    logic [7:0]  enum_o, ext_ctl_o, ctl_stat_o;
    logic        key_active_o;

    uart_bank_regs u_uart_bank_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte_i(rx_byte),
        .int_ident_i(int_ident), .line_stat_i(line_stat), .modem_stat_i(modem_stat),
        .good_count_i(good_count), .bad_flag_i(bad_flag), .tx_push_o(tx_push_o),
        .tx_byte_o(tx_byte_o), .divisor_o(divisor_o), .int_enable_o(int_enable_o),
        .fifo_ctl_o(fifo_ctl_o), .line_ctl_o(line_ctl_o), .modem_ctl_o(modem_ctl_o),
        .feature_o(feature_o), .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o),
        .xoff2_o(xoff2_o), .rx_low_o(rx_low_o), .rx_high_o(rx_high_o),
        .rx_trig_o(rx_trig_o), .tx_thresh_o(tx_thresh_o), .enum_o(enum_o),
        .ext_ctl_o(ext_ctl_o), .ctl_stat_o(ctl_stat_o), .key_active_o(key_active_o)
    );

    always #2 clk = ~clk;

    // behavioural model
    logic [7:0] m_dll, m_dlm, m_ier, m_fcr, m_lcr, m_mcr, m_scr, m_efr, m_txb, m_rdata;
    logic       m_txp;
    logic [7:0] m_bank [0:3][0:3];
    string      m_rtag;
    int         n_cmp = 0;
    int         n_bad = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [2:0] a, output string tag);
        logic       open;
        int         bk;
        open = (m_lcr == KEY);
        bk   = int'(m_efr[7:6]);
        tag  = "R2";
        if (a == 3'd3) begin tag = "R10"; return m_lcr; end
        if (a <= 3'd1 && m_lcr[7]) begin tag = "R3"; return (a == 3'd0) ? m_dll : m_dlm; end
        if (a == 3'd0) return rx_byte;
        if (a == 3'd1) return m_ier;
        if (a == 3'd2) begin
            if (open) begin tag = "R4"; return m_efr; end
            return int_ident;
        end
        if (open) begin
            if (bk == 3) begin tag = "R8"; return 8'h00; end
            if (bk == 2 && a == 3'd5) begin tag = "R7"; return HWID; end
            tag = (bk == 0) ? "R5" : (bk == 1) ? "R6" : "R7";
            return m_bank[bk][int'(a) - 4];
        end
        if (a == 3'd4) return m_mcr;
        if (a == 3'd5) return line_stat;
        if (a == 3'd6) return modem_stat;
        tag = "R9";
        if (m_efr[4]) return {bad_flag, good_count};
        return m_scr;
    endfunction

    task automatic m_write(input logic [2:0] a, input logic [7:0] d);
        logic open;
        int   bk;
        open = (m_lcr == KEY);
        bk   = int'(m_efr[7:6]);
        if (a == 3'd3) m_lcr = d;
        else if (a == 3'd0 && m_lcr[7]) m_dll = d;
        else if (a == 3'd1 && m_lcr[7]) m_dlm = d;
        else if (a == 3'd0) begin m_txb = d; m_txp = 1'b1; end
        else if (a == 3'd1) m_ier = d;
        else if (a == 3'd2) begin
            if (open) m_efr = d; else m_fcr = d;
        end else if (open) begin
            if (bk != 3 && !(bk == 2 && a == 3'd5)) m_bank[bk][int'(a) - 4] = d;
        end else if (a == 3'd4) m_mcr = d;
        else if (a == 3'd7) m_scr = d;
    endtask

    task automatic compare_all(input string rtag);
        chk(rtag,  {8'h00, bus_rdata},    {8'h00, m_rdata});
        chk("R2",  {15'h0, tx_push_o},    {15'h0, m_txp});
        chk("R2",  {8'h00, tx_byte_o},    {8'h00, m_txb});
        chk("R3",  divisor_o,             {m_dlm, m_dll});
        chk("R2",  {8'h00, int_enable_o}, {8'h00, m_ier});
        chk("R2",  {8'h00, fifo_ctl_o},   {8'h00, m_fcr});
        chk("R2",  {8'h00, modem_ctl_o},  {8'h00, m_mcr});
        chk("R10", {8'h00, line_ctl_o},   {8'h00, m_lcr});
        chk("R4",  {15'h0, key_active_o}, {15'h0, (m_lcr == KEY)});
        chk("R4",  {8'h00, feature_o},    {8'h00, m_efr});
        chk("R5",  {xon1_o, xon2_o},      {m_bank[0][0], m_bank[0][1]});
        chk("R5",  {xoff1_o, xoff2_o},    {m_bank[0][2], m_bank[0][3]});
        chk("R6",  {rx_low_o, rx_high_o}, {m_bank[1][0], m_bank[1][1]});
        chk("R6",  {rx_trig_o, tx_thresh_o}, {m_bank[1][2], m_bank[1][3]});
        chk("R7",  {enum_o, ext_ctl_o},   {m_bank[2][0], m_bank[2][2]});
        chk("R7",  {8'h00, ctl_stat_o},   {8'h00, m_bank[2][3]});
    endtask

    task automatic cyc(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] d);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        m_txp = 1'b0;
        if (rd) m_rdata = m_read(a, m_rtag);
        if (wr) m_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        compare_all(rd ? m_rtag : "R11");
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        m_dll = 0; m_dlm = 0; m_ier = 0; m_fcr = 0; m_lcr = 0; m_mcr = 0;
        m_scr = 0; m_efr = 0; m_txb = 0; m_rdata = 0; m_txp = 0;
        for (int b = 0; b < 4; b++) for (int s = 0; s < 4; s++) m_bank[b][s] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        compare_all("R1");
        chk("R1", {15'h0, key_active_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2 normal map
        wr(3'd1, 8'h0F); wr(3'd4, 8'h13); wr(3'd7, 8'h5A); wr(3'd2, 8'hC7);
        wr(3'd5, 8'hEE); wr(3'd6, 8'hDD);
        for (int a = 0; a < 8; a++) rd(3'(a));
        wr(3'd0, 8'h41);
        chk("R2", {15'h0, tx_push_o}, 16'h1);
        rd(3'd0);
        chk("R2", {15'h0, tx_push_o}, 16'h0);

        // R3 divisor latch
        wr(3'd3, 8'h83); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        chk("R3", divisor_o, 16'h1234);
        rd(3'd0); rd(3'd1);
        wr(3'd3, 8'h03);

        // R4 key opens the enhanced view
        wr(3'd3, KEY); rd(3'd2); wr(3'd2, 8'h10);
        chk("R4", {8'h00, fifo_ctl_o}, 16'h00C7);
        wr(3'd0, 8'h0C); wr(3'd1, 8'h00);
        // R5 bank 0
        wr(3'd4, 8'h11); wr(3'd5, 8'h13); wr(3'd6, 8'h91); wr(3'd7, 8'h93);
        for (int a = 4; a < 8; a++) rd(3'(a));
        // R6 bank 1
        wr(3'd2, 8'h50);
        wr(3'd4, 8'h08); wr(3'd5, 8'h30); wr(3'd6, 8'h20); wr(3'd7, 8'h10);
        for (int a = 4; a < 8; a++) rd(3'(a));
        // R7 bank 2
        wr(3'd2, 8'h90);
        wr(3'd4, 8'hE1); wr(3'd5, 8'hFF); wr(3'd6, 8'hE3); wr(3'd7, 8'hE4);
        for (int a = 4; a < 8; a++) rd(3'(a));
        chk("R7", {8'h00, bus_rdata}, 16'h00E4);
        rd(3'd5);
        chk("R7", {8'h00, bus_rdata}, {8'h00, HWID});
        // R8 empty bank
        wr(3'd2, 8'hD0);
        for (int a = 4; a < 8; a++) wr(3'(a), 8'hAA);
        for (int a = 4; a < 8; a++) rd(3'(a));
        chk("R8", {8'h00, bus_rdata}, 16'h0000);
        rd(3'd3);

        // R10 leave, values kept; R9 good length
        wr(3'd3, 8'h03);
        rd(3'd2);
        chk("R10", {8'h00, bus_rdata}, {8'h00, int_ident});
        rd(3'd7);
        chk("R9", {8'h00, bus_rdata}, {8'h00, bad_flag, good_count});
        wr(3'd7, 8'h77); wr(3'd4, 8'h21);
        chk("R10", {xon1_o, enum_o}, 16'h11E1);
        wr(3'd3, KEY); wr(3'd2, 8'h80); wr(3'd3, 8'h03);
        rd(3'd7);
        chk("R9", {8'h00, bus_rdata}, 16'h0077);

        // R11 read and write in the same cycle
        cyc(1'b1, 1'b1, 3'd3, KEY);
        chk("R11", {8'h00, bus_rdata}, 16'h0003);
        rd(3'd2);
        chk("R11", {8'h00, bus_rdata}, 16'h0080);

        // mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = lfsr[15:8];
            if (lfsr[2:0] == 3'd3 && lfsr[5]) d = KEY;
            rx_byte    = lfsr[11:4];
            line_stat  = lfsr[7:0] ^ 8'h5A;
            modem_stat = lfsr[15:8] ^ 8'h33;
            int_ident  = lfsr[9:2];
            good_count = lfsr[13:7];
            bad_flag   = lfsr[6];
            cyc(lfsr[3], lfsr[4], lfsr[2:0], d);
        end

        summary();
        $finish;
    end

endmodule